// File: doc/BRIEF.md
# SPI Master Frame Timing Sequencer

This block produces the chip-select and serial-clock waveform for one SPI master frame, counted in system-clock cycles. A start pulse opens a frame. Chip select goes low, a setup delay runs, and then a set number of clock bits is generated. A hold delay follows, chip select is released, and an idle gap must pass before the next frame may begin. The block also gives a strobe on every falling clock edge, which a separate shifter can use, a busy flag, and a one-cycle done pulse at the end of the gap.

Each of the four intervals is given as a two-bit prescaler code and a power-of-two scaler code. The intervals are the clock period, the chip-select-to-clock setup, the last-edge-to-release hold and the idle gap. A double-rate bit halves the clock period. All fields are sampled in the cycle a frame begins and are held for the whole frame. A start that arrives during the hold or the gap is kept until the gap ends, so the next frame then follows back to back.

Top module: `spi_frame_timer`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `cs_n` is 1 and `sck`, `busy`, `shift_stb` and `done` are 0.
- R2: The first rising edge of `sck` comes exactly Ds cycles after the edge that drives `cs_n` low. Ds = p × 2^(k+1), where k is the `csc_scl` code and p is 1, 3, 5 or 7 for `csc_pre` codes 0, 1, 2 and 3.
- R3: The clock period is P = b × 2^(s+1) / (1 + `dbr`) cycles, where s is the `baud_scl` code and b is 2, 3, 5 or 7 for `baud_pre` codes 0 to 3. Every high phase lasts floor(P/2) cycles and every low phase lasts P − floor(P/2) cycles. With codes 0 and 0 and `dbr` = 1, `sck` toggles every cycle.
- R4: A frame has exactly `frame_len` + 1 rising edges of `sck` (`frame_len` is 5 bits, so 1 to 32 bits), and `sck` is high only while `cs_n` is low.
- R5: `cs_n` rises exactly Dh cycles after the falling `sck` edge of the last bit. Dh is computed from `asc_pre` and `asc_scl` with the R2 formula.
- R6: Once `cs_n` rises, it stays high for at least Dg cycles, where Dg is computed from `gap_pre` and `gap_scl` with the R2 formula. If `start` is seen while chip select is in the hold or the gap, the next frame begins exactly Dg cycles after `cs_n` rose.
- R7: A `start` seen while in the setup delay or the clock burst is ignored: no frame follows.
- R8: `shift_stb` is high for one cycle, in the same cycle in which `sck` has just fallen, and at no other time. It gives `frame_len` + 1 pulses per frame.
- R9: `busy` is high whenever `cs_n` is low and through the gap. `done` is a single-cycle pulse that appears Dg cycles after `cs_n` rises.
- R10: All timing fields and `frame_len` are sampled in the cycle a frame begins. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Frame request |
| baud_pre | input | 2 | Clock prescaler code (2, 3, 5, 7) |
| baud_scl | input | SCL_W | Clock scaler code, 2^(code+1) |
| dbr | input | 1 | Double-rate: halves the clock period |
| csc_pre | input | 2 | Setup delay prescaler code (1, 3, 5, 7) |
| csc_scl | input | SCL_W | Setup delay scaler code |
| asc_pre | input | 2 | Hold delay prescaler code |
| asc_scl | input | SCL_W | Hold delay scaler code |
| gap_pre | input | 2 | Idle gap prescaler code |
| gap_scl | input | SCL_W | Idle gap scaler code |
| frame_len | input | LEN_W | Bits per frame minus one |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock, idles low |
| shift_stb | output | 1 | Pulse on each falling sck edge |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle pulse at the end of the gap |

## Verification
The assertions take for granted that every field stays stable from the cycle `start` is presented until the frame actually begins, including a start that is held pending during the gap. They also rely on every decoded interval being at least two cycles, which the encodings guarantee. The stimulus drives new field values only while the sequencer is idle or, for back-to-back cases, in the same cycle as the pending start, and then holds them. The only exception is a deliberate change in mid-burst, used to show that the sampled values are kept. Scaler codes are kept small in the random frames so that the long delays stay inside the cycle budget, while directed frames cover the fastest clock, odd periods, 32-bit frames and delays of 96 cycles.

// File: rtl/spi_ft_pkg.sv
package spi_ft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_XFER  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_GAP   = 3'd4
  } seq_state_e;

  localparam int unsigned DLY_CSC = 0;
  localparam int unsigned DLY_ASC = 1;
  localparam int unsigned DLY_GAP = 2;
  localparam int unsigned DLY_NUM = 3;

  // Baud prescaler code -> divisor 2, 3, 5, 7
  function automatic int unsigned baud_prescale(input logic [1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 3;
      2'd2:    return 5;
      default: return 7;
    endcase
  endfunction

  // Delay prescaler code -> 1, 3, 5, 7 (odd sequence)
  function automatic int unsigned delay_prescale(input logic [1:0] code);
    return (32'(code) << 1) + 32'd1;
  endfunction

  // Scaler code -> 2^(code+1)
  function automatic int unsigned scale_pow2(input int unsigned code);
    return 32'd2 << code;
  endfunction

endpackage

// File: rtl/spi_ft_dly_calc.sv
module spi_ft_dly_calc #(
  parameter int SCL_W = 4,
  parameter int CNT_W = 19
) (
  input  logic [1:0]       pre_code,
  input  logic [SCL_W-1:0] scl_code,
  output logic [CNT_W-1:0] cycles
);
  import spi_ft_pkg::*;

  always_comb begin
    cycles = CNT_W'(delay_prescale(pre_code) * scale_pow2(32'(scl_code)));
  end
endmodule

// File: rtl/spi_ft_timing.sv
module spi_ft_timing #(
  parameter int SCL_W = 4,
  parameter int CNT_W = 19
) (
  input  logic [1:0]                              baud_pre,
  input  logic [SCL_W-1:0]                        baud_scl,
  input  logic                                    dbr,
  input  logic [spi_ft_pkg::DLY_NUM-1:0][1:0]       dly_pre,
  input  logic [spi_ft_pkg::DLY_NUM-1:0][SCL_W-1:0] dly_scl,
  output logic [spi_ft_pkg::DLY_NUM-1:0][CNT_W-1:0] dly_cyc,
  output logic [CNT_W-1:0]                        hi_cyc,
  output logic [CNT_W-1:0]                        lo_cyc
);
  import spi_ft_pkg::*;

  logic [CNT_W-1:0] period_full;
  logic [CNT_W-1:0] period;

  for (genvar g = 0; g < DLY_NUM; g++) begin : g_dly
    spi_ft_dly_calc #(.SCL_W(SCL_W), .CNT_W(CNT_W)) u_calc (
      .pre_code (dly_pre[g]),
      .scl_code (dly_scl[g]),
      .cycles   (dly_cyc[g])
    );
  end

  always_comb begin
    period_full = CNT_W'(baud_prescale(baud_pre) * scale_pow2(32'(baud_scl)));
    period      = dbr ? (period_full >> 1) : period_full;
    hi_cyc      = period >> 1;
    lo_cyc      = period - hi_cyc;
  end
endmodule

// File: rtl/spi_ft_seq.sv
module spi_ft_seq #(
  parameter int CNT_W = 19,
  parameter int LEN_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CNT_W-1:0]       csc_cyc,
  input  logic [CNT_W-1:0]       asc_cyc,
  input  logic [CNT_W-1:0]       gap_cyc,
  input  logic [CNT_W-1:0]       hi_cyc,
  input  logic [CNT_W-1:0]       lo_cyc,
  input  logic [LEN_W-1:0]       last_bit,
  output logic                   frame_begin,
  output spi_ft_pkg::seq_state_e state,
  output logic                   cs_n,
  output logic                   sck,
  output logic                   shift_stb,
  output logic                   done,
  output logic                   busy
);
  import spi_ft_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] bit_idx;
  logic             pend;
  logic             cnt_zero;
  logic             late_start;
  logic             last_fall;

  always_comb begin
    cnt_zero    = (cnt == '0);
    frame_begin = ((state == ST_IDLE) && start) ||
                  ((state == ST_GAP) && cnt_zero && (pend || start));
    late_start  = start && ((state == ST_HOLD) || (state == ST_GAP)) && !frame_begin;
    last_fall   = (bit_idx == last_bit);
    busy        = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      pend      <= 1'b0;
      cs_n      <= 1'b1;
      sck       <= 1'b0;
      shift_stb <= 1'b0;
      done      <= 1'b0;
    end else begin
      shift_stb <= 1'b0;
      done      <= 1'b0;
      if (late_start) pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (frame_begin) begin
            state <= ST_SETUP;
            cs_n  <= 1'b0;
            cnt   <= csc_cyc - 1'b1;
          end
        end
        ST_SETUP: begin
          if (cnt_zero) begin
            state   <= ST_XFER;
            sck     <= 1'b1;
            cnt     <= hi_cyc - 1'b1;
            bit_idx <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_XFER: begin
          if (!cnt_zero) begin
            cnt <= cnt - 1'b1;
          end else if (sck) begin
            sck       <= 1'b0;
            shift_stb <= 1'b1;
            if (last_fall) begin
              state <= ST_HOLD;
              cnt   <= asc_cyc - 1'b1;
            end else begin
              cnt <= lo_cyc - 1'b1;
            end
          end else begin
            sck     <= 1'b1;
            cnt     <= hi_cyc - 1'b1;
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt_zero) begin
            state <= ST_GAP;
            cs_n  <= 1'b1;
            cnt   <= gap_cyc - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt_zero) begin
            done <= 1'b1;
            pend <= 1'b0;
            if (frame_begin) begin
              state <= ST_SETUP;
              cs_n  <= 1'b0;
              cnt   <= csc_cyc - 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_frame_timer.sv
module spi_frame_timer #(
  parameter int SCL_W = 4,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       baud_pre,
  input  logic [SCL_W-1:0] baud_scl,
  input  logic             dbr,
  input  logic [1:0]       csc_pre,
  input  logic [SCL_W-1:0] csc_scl,
  input  logic [1:0]       asc_pre,
  input  logic [SCL_W-1:0] asc_scl,
  input  logic [1:0]       gap_pre,
  input  logic [SCL_W-1:0] gap_scl,
  input  logic [LEN_W-1:0] frame_len,
  output logic             cs_n,
  output logic             sck,
  output logic             shift_stb,
  output logic             busy,
  output logic             done
);
  import spi_ft_pkg::*;

  localparam int CNT_W = 3 + (1 << SCL_W);

  logic [DLY_NUM-1:0][1:0]       dly_pre;
  logic [DLY_NUM-1:0][SCL_W-1:0] dly_scl;
  logic [DLY_NUM-1:0][CNT_W-1:0] live_dly;
  logic [CNT_W-1:0]              live_hi;
  logic [CNT_W-1:0]              live_lo;

  logic [CNT_W-1:0] held_asc;
  logic [CNT_W-1:0] held_gap;
  logic [CNT_W-1:0] held_hi;
  logic [CNT_W-1:0] held_lo;
  logic [LEN_W-1:0] held_len;

  logic       frame_begin;
  seq_state_e seq_state;

  always_comb begin
    dly_pre[DLY_CSC] = csc_pre;
    dly_pre[DLY_ASC] = asc_pre;
    dly_pre[DLY_GAP] = gap_pre;
    dly_scl[DLY_CSC] = csc_scl;
    dly_scl[DLY_ASC] = asc_scl;
    dly_scl[DLY_GAP] = gap_scl;
  end

  spi_ft_timing #(.SCL_W(SCL_W), .CNT_W(CNT_W)) u_timing (
    .baud_pre (baud_pre),
    .baud_scl (baud_scl),
    .dbr      (dbr),
    .dly_pre  (dly_pre),
    .dly_scl  (dly_scl),
    .dly_cyc  (live_dly),
    .hi_cyc   (live_hi),
    .lo_cyc   (live_lo)
  );

  // Frame attributes frozen at the cycle the frame begins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_asc <= '0;
      held_gap <= '0;
      held_hi  <= '0;
      held_lo  <= '0;
      held_len <= '0;
    end else if (frame_begin) begin
      held_asc <= live_dly[DLY_ASC];
      held_gap <= live_dly[DLY_GAP];
      held_hi  <= live_hi;
      held_lo  <= live_lo;
      held_len <= frame_len;
    end
  end

  spi_ft_seq #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .csc_cyc     (live_dly[DLY_CSC]),
    .asc_cyc     (held_asc),
    .gap_cyc     (held_gap),
    .hi_cyc      (held_hi),
    .lo_cyc      (held_lo),
    .last_bit    (held_len),
    .frame_begin (frame_begin),
    .state       (seq_state),
    .cs_n        (cs_n),
    .sck         (sck),
    .shift_stb   (shift_stb),
    .done        (done),
    .busy        (busy)
  );
endmodule

// File: rtl/spi_ft_checker.sv
module spi_ft_checker #(
  parameter int LEN_W = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   sck,
  input logic                   shift_stb,
  input logic                   busy,
  input logic                   done,
  input spi_ft_pkg::seq_state_e state,
  input logic [LEN_W-1:0]       held_len
);
  import spi_ft_pkg::*;

  logic             sck_q;
  logic [LEN_W:0]   rise_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sck_q <= sck;
      if (cs_n)              rise_cnt <= '0;
      else if (sck && !sck_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (cs_n && !sck && !busy && !shift_stb)); // R1
  AST_SETUP_NO_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETUP) |-> (!sck && !cs_n)); // R2
  AST_SCK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n); // R4
  AST_BIT_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rise_cnt == {1'b0, held_len} + 1'b1)); // R4
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n); // R6
  AST_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> shift_stb); // R8
  AST_SHIFT_ONLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> $fell(sck)); // R8
  AST_BUSY_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

bind spi_frame_timer spi_ft_checker #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sck       (sck),
  .shift_stb (shift_stb),
  .busy      (busy),
  .done      (done),
  .state     (seq_state),
  .held_len  (held_len)
);

// File: tb/spi_frame_timer_bench.sv
module spi_frame_timer_bench;
  localparam int SCL_W = 4;
  localparam int LEN_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] r_bpre = '0, r_cpre = '0, r_apre = '0, r_gpre = '0;
  logic [SCL_W-1:0] r_bscl = '0, r_cscl = '0, r_ascl = '0, r_gscl = '0;
  logic r_dbr = 1'b0;
  logic [LEN_W-1:0] r_len = '0;
  logic cs_n, sck, shift_stb, busy, done;

  always #4 clk = ~clk;

  spi_frame_timer #(.SCL_W(SCL_W), .LEN_W(LEN_W)) u_spi_frame_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .baud_pre(r_bpre), .baud_scl(r_bscl), .dbr(r_dbr),
    .csc_pre(r_cpre), .csc_scl(r_cscl),
    .asc_pre(r_apre), .asc_scl(r_ascl),
    .gap_pre(r_gpre), .gap_scl(r_gscl),
    .frame_len(r_len),
    .cs_n(cs_n), .sck(sck), .shift_stb(shift_stb), .busy(busy), .done(done)
  );

  int checks = 0, fails = 0;
  int e_csc, e_asc, e_gap, e_hi, e_lo, e_n;

  // Monitor state (sampled on falling clock edges)
  int cyc = 0, t_csf = 0, t_csr = 0, t_r1 = 0, t_lrise = 0, t_lfall = 0, t_done = 0;
  int rises = 0, shifts = 0, bad_hi = 0, bad_lo = 0, bad_shift = 0, bad_busy = 0;
  int done_cnt = 0, last_gap = 0;
  bit p_cs = 1'b1, p_sck = 1'b0;

  function automatic int b_pre(input int c);
    case (c) 0: return 2; 1: return 3; 2: return 5; default: return 7; endcase
  endfunction
  function automatic int d_pre(input int c);
    case (c) 0: return 1; 1: return 3; 2: return 5; default: return 7; endcase
  endfunction
  function automatic int pw(input int c);
    int v = 1;
    for (int i = 0; i <= c; i++) v = v * 2;
    return v;
  endfunction

  task automatic calc_exp();
    int p;
    p     = b_pre(int'(r_bpre)) * pw(int'(r_bscl));
    if (r_dbr) p = p / 2;
    e_hi  = p / 2;
    e_lo  = p - e_hi;
    e_csc = d_pre(int'(r_cpre)) * pw(int'(r_cscl));
    e_asc = d_pre(int'(r_apre)) * pw(int'(r_ascl));
    e_gap = d_pre(int'(r_gpre)) * pw(int'(r_gscl));
    e_n   = int'(r_len) + 1;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (p_cs && !cs_n) begin
        last_gap = cyc - t_csr; t_csf = cyc;
        rises = 0; shifts = 0; bad_hi = 0; bad_lo = 0; bad_shift = 0; bad_busy = 0;
      end
      if (!p_cs && cs_n) t_csr = cyc;
      if (!p_sck && sck) begin
        rises++;
        if (rises == 1) t_r1 = cyc;
        else if (cyc - t_lfall != e_lo) bad_lo++;
        t_lrise = cyc;
      end
      if (p_sck && !sck) begin
        if (cyc - t_lrise != e_hi) bad_hi++;
        t_lfall = cyc;
      end
      if (shift_stb) shifts++;
      if (shift_stb != (p_sck && !sck)) bad_shift++;
      if (!cs_n && !busy) bad_busy++;
      if (done) begin t_done = cyc; done_cnt++; end
      p_cs = cs_n; p_sck = sck;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int n0 = done_cnt;
    while (done_cnt == n0) @(negedge clk);
  endtask

  task automatic check_frame(input string tag);
    chk(t_r1 - t_csf == e_csc, "R2", {tag, " setup"}, t_r1 - t_csf, e_csc);
    chk(bad_hi == 0, "R3", {tag, " high phases"}, bad_hi, 0);
    chk(bad_lo == 0, "R3", {tag, " low phases"}, bad_lo, 0);
    chk(rises == e_n, "R4", {tag, " bit count"}, rises, e_n);
    chk(t_csr - t_lfall == e_asc, "R5", {tag, " hold"}, t_csr - t_lfall, e_asc);
    chk(shifts == e_n && bad_shift == 0, "R8", {tag, " shift strobes"}, shifts, e_n);
    chk(t_done - t_csr == e_gap, "R9", {tag, " done after gap"}, t_done - t_csr, e_gap);
    chk(bad_busy == 0, "R9", {tag, " busy while selected"}, bad_busy, 0);
  endtask

  task automatic set_f(input int bp, input int bs, input int db, input int cp, input int cs,
                       input int ap, input int as, input int gp, input int gs, input int ln);
    r_bpre = 2'(bp); r_bscl = SCL_W'(bs); r_dbr = 1'(db);
    r_cpre = 2'(cp); r_cscl = SCL_W'(cs);
    r_apre = 2'(ap); r_ascl = SCL_W'(as);
    r_gpre = 2'(gp); r_gscl = SCL_W'(gs);
    r_len  = LEN_W'(ln);
    calc_exp();
  endtask

  task automatic run_frame(input string tag);
    calc_exp();
    pulse_start();
    wait_done();
    check_frame(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    int gsave;
    seed = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cs_n && !sck && !busy && !shift_stb && !done, "R1", "idle outputs after reset",
        {cs_n, sck, busy, shift_stb, done}, 5'b10000);

    // R3 corner: fastest clock, toggles every cycle
    set_f(0, 0, 1, 0, 0, 0, 0, 0, 0, 7);   run_frame("fastest");
    // R3 corner: prescaler 3, double rate -> odd period 3
    set_f(1, 0, 1, 0, 1, 1, 0, 0, 1, 4);   run_frame("odd period");
    set_f(0, 0, 0, 2, 0, 0, 1, 3, 0, 2);   run_frame("single rate");
    // R2/R5: 3 x 32 = 96 cycle delays, 32-bit frame
    set_f(3, 1, 0, 1, 4, 1, 4, 1, 2, 31);  run_frame("long delays");
    // R4 corner: single-bit frame
    set_f(2, 1, 1, 0, 0, 3, 0, 0, 0, 0);   run_frame("one bit");

    // R1 after a frame: back to idle
    repeat (3) @(negedge clk);
    chk(cs_n && !sck && !busy, "R1", "idle outputs between frames", {cs_n, sck, busy}, 3'b100);

    // R6: start during the gap held until gap expires; R10 new fields taken at begin
    set_f(0, 1, 0, 0, 1, 0, 1, 1, 1, 3);
    pulse_start();
    gsave = e_gap;
    while (!(busy && cs_n)) @(negedge clk);
    set_f(1, 0, 0, 1, 0, 2, 0, 0, 2, 5);
    pulse_start();
    wait_done(); wait_done();
    chk(last_gap == gsave, "R6", "gap with start pending in gap", last_gap, gsave);
    check_frame("R10 after pending");

    // R6: start during hold held as well
    set_f(0, 0, 1, 0, 0, 2, 2, 0, 1, 2);
    pulse_start();
    gsave = e_gap;
    while (!(busy && !cs_n && rises == e_n && !sck)) @(negedge clk);
    pulse_start();
    wait_done(); wait_done();
    chk(last_gap == gsave, "R6", "gap with start pending in hold", last_gap, gsave);
    check_frame("pending from hold");

    // R7: start during burst ignored; R10 mid-frame field change ignored
    set_f(2, 1, 0, 1, 1, 1, 1, 0, 1, 9);
    pulse_start();
    while (!sck) @(negedge clk);
    r_apre = 2'd3; r_ascl = 4'd3; r_len = 5'd1; r_bpre = 2'd0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    check_frame("R10 mid-frame change");
    repeat (20) @(negedge clk);
    chk(cs_n && !busy, "R7", "no frame after start in burst", {cs_n, busy}, 2'b10);

    // R7: start during setup ignored
    set_f(0, 0, 0, 3, 2, 0, 0, 0, 0, 1);
    pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    check_frame("setup start");
    repeat (20) @(negedge clk);
    chk(cs_n && !busy, "R7", "no frame after start in setup", {cs_n, busy}, 2'b10);

    // Random frames
    for (int k = 0; k < 20; k++) begin
      set_f(int'($urandom_range(3)), int'($urandom_range(2)), int'($urandom_range(1)),
            int'($urandom_range(3)), int'($urandom_range(4)),
            int'($urandom_range(3)), int'($urandom_range(4)),
            int'($urandom_range(3)), int'($urandom_range(4)),
            int'($urandom_range(31)));
      run_frame("random");
      repeat (int'($urandom_range(3))) @(negedge clk);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule